// File: doc/BRIEF.md
# Lock-Step Handshake Fork

This block takes one valid/ready input channel whose payload is a bundle of `LANES` equal-width fields and fans it out into `LANES` independent valid/ready output lanes, one field per lane. The producer on the input side cannot retire part of a bundle, so the bundle is consumed only in a cycle in which every lane accepts its own field. In every other cycle no lane takes anything.

To get this behaviour, each lane's valid is qualified by the readiness of all the *other* lanes. A lane therefore sees a valid offer only when its own acceptance would complete the whole transfer. The upstream ready is the conjunction of all lane readies. The handshake path is purely combinational. Nested groupings of lanes are handled by flattening them into one lane set before they reach the block. The downstream stages are expected to drive their readies from registers, so that no combinational loop closes through the fork.

A build-time parameter selects how the "all readies except mine" terms are formed. The choices are a prefix/suffix AND scan or a direct per-lane reduction. The function is the same in both cases.

Top module: `lockstep_fork`

## Requirements
- R1: `ready_o` is 1 exactly when every bit of `ready_i` is 1.
- R2: `valid_o[i]` is 1 exactly when `valid_i` is 1 and every `ready_i[j]` with j different from i is 1.
- R3: Lane i carries field i: `data_o[i*FIELD_W +: FIELD_W]` equals `data_i[i*FIELD_W +: FIELD_W]`. Field 0 is in the least significant bits.
- R4: In any cycle, the lane handshakes (`valid_o[i] & ready_i[i]`) are either all 1 or all 0. No lane takes its field while another lane is not ready.
- R5: The upstream handshake (`valid_i & ready_o`) occurs exactly in the cycles in which every lane handshake occurs.
- R6: While `valid_i` is 0, every bit of `valid_o` is 0.
- R7: A lane's own ready does not affect its own valid. With `valid_i` high and all other lanes ready, a stalled lane still sees `valid_o` high.
- R8: Under arbitrary per-lane ready stalls, with the producer holding each bundle until it is accepted, every lane receives every field of every bundle exactly once and in bundle order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Bundle offered by the producer |
| ready_o | output | 1 | Bundle accepted this cycle when valid_i is high |
| data_i | input | LANES*FIELD_W | Bundle; field i at bits i*FIELD_W +: FIELD_W |
| valid_o | output | LANES | Per-lane offer, gated by the other lanes' readies |
| ready_i | input | LANES | Per-lane acceptance from the downstream stages |
| data_o | output | LANES*FIELD_W | Per-lane field, same packing as data_i |

## Verification
The assertions assume that the inputs are settled whenever the combinational checks are evaluated. They also assume that the downstream readies do not depend combinationally on `valid_o`. The bench meets both conditions by changing `valid_i`, `data_i` and `ready_i` only just after the rising edge, from registered-style stimulus that never looks at the outputs in the same cycle. The bench also keeps the producer to the rule that an offered bundle is held unchanged until it is accepted. The in-order delivery check (R8) depends on that rule.

// File: rtl/lockstep_fork_pkg.sv
package lockstep_fork_pkg;

  // How the "all readies except lane i" terms are built
  typedef enum logic [0:0] {
    EXCL_SCAN   = 1'b0,  // shared prefix/suffix AND chains
    EXCL_DIRECT = 1'b1   // one independent reduction per lane
  } excl_mode_e;

endpackage

// File: rtl/lsf_excl_and.sv
module lsf_excl_and
  import lockstep_fork_pkg::*;
#(
  parameter int unsigned N    = 4,
  parameter excl_mode_e  MODE = EXCL_SCAN
) (
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] excl_o,   // AND of all bits except bit i
  output logic         all_o     // AND of all bits
);

  if (MODE == EXCL_SCAN) begin : g_scan
    logic [N:0] pre;  // pre[k] = AND of bits_i[k-1:0]
    logic [N:0] suf;  // suf[k] = AND of bits_i[N-1:k]
    assign pre[0] = 1'b1;
    assign suf[N] = 1'b1;
    for (genvar k = 0; k < N; k++) begin : g_chain
      assign pre[k+1] = pre[k] & bits_i[k];
      assign suf[N-1-k] = suf[N-k] & bits_i[N-1-k];
    end
    for (genvar i = 0; i < N; i++) begin : g_lane
      assign excl_o[i] = pre[i] & suf[i+1];
    end
    assign all_o = pre[N];
  end else begin : g_direct
    for (genvar i = 0; i < N; i++) begin : g_lane
      logic [N-1:0] mask;
      always_comb begin
        mask    = bits_i;
        mask[i] = 1'b1;
      end
      assign excl_o[i] = &mask;
    end
    assign all_o = &bits_i;
  end

endmodule

// File: rtl/lsf_lane_split.sv
module lsf_lane_split #(
  parameter int unsigned N       = 4,
  parameter int unsigned FIELD_W = 8,
  localparam int unsigned BUS_W  = N * FIELD_W
) (
  input  logic [BUS_W-1:0] bundle_i,
  output logic [BUS_W-1:0] lanes_o
);

  for (genvar i = 0; i < N; i++) begin : g_field
    logic [FIELD_W-1:0] field;
    assign field = bundle_i[i*FIELD_W +: FIELD_W];
    assign lanes_o[i*FIELD_W +: FIELD_W] = field;
  end

endmodule

// File: rtl/lockstep_fork.sv
module lockstep_fork
  import lockstep_fork_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned FIELD_W   = 8,
  parameter excl_mode_e  EXCL_MODE = EXCL_SCAN,
  localparam int unsigned BUS_W    = LANES * FIELD_W
) (
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [BUS_W-1:0] data_i,
  output logic [LANES-1:0] valid_o,
  input  logic [LANES-1:0] ready_i,
  output logic [BUS_W-1:0] data_o
);

  logic [LANES-1:0] others_rdy;
  logic             all_rdy;

  lsf_excl_and #(
    .N    (LANES),
    .MODE (EXCL_MODE)
  ) u_excl (
    .bits_i (ready_i),
    .excl_o (others_rdy),
    .all_o  (all_rdy)
  );

  lsf_lane_split #(
    .N       (LANES),
    .FIELD_W (FIELD_W)
  ) u_split (
    .bundle_i (data_i),
    .lanes_o  (data_o)
  );

  assign ready_o = all_rdy;
  assign valid_o = {LANES{valid_i}} & others_rdy;

  // Checks on settled combinational values
  logic [LANES-1:0] lane_hs;
  assign lane_hs = valid_o & ready_i;

  always_comb begin
    // R4: lanes complete all together or not at all
    p_all_or_none_r4: assert (lane_hs == '0 || &lane_hs);
    // R5: upstream completes exactly when every lane does
    p_up_matches_lanes_r5: assert ((valid_i & ready_o) == (&lane_hs));
    // R6: no offer downstream without an offer upstream
    p_idle_quiet_r6: assert (valid_i || valid_o == '0);
    // R1: upstream ready implies no lane is stalled
    p_ready_all_r1: assert (!ready_o || &ready_i);
  end

endmodule

// File: tb/lockstep_fork_tb.sv
`timescale 1ns/1ps
module lockstep_fork_tb;
  import lockstep_fork_pkg::*;

  localparam int unsigned LANES   = 4;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned BUS_W   = LANES * FIELD_W;
  localparam int unsigned RAND_CYC = 3000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic             ready_o;
  logic [BUS_W-1:0] data_i = '0;
  logic [LANES-1:0] valid_o;
  logic [LANES-1:0] ready_i = '0;
  logic [BUS_W-1:0] data_o;

  always #2 clk = ~clk;  // 250 MHz

  lockstep_fork #(
    .LANES     (LANES),
    .FIELD_W   (FIELD_W),
    .EXCL_MODE (EXCL_SCAN)
  ) u_dut (
    .valid_i (valid_i),
    .ready_o (ready_o),
    .data_i  (data_i),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .data_o  (data_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int n_sent = 0;
  int n_recv = 0;
  bit holding = 1'b0;
  logic [FIELD_W-1:0] exp_q [LANES][$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FIELD_W-1:0] field_val(int seq, int lane);
    return FIELD_W'((seq * 37 + lane * 101 + 5) & 8'hff);
  endfunction

  // Driver: changes inputs just after the rising edge; pushes expectations
  task automatic drive_cycle(input bit want, input logic [LANES-1:0] rdy);
    @(posedge clk);
    #1;
    if (!holding && want) begin
      for (int i = 0; i < LANES; i++) begin
        data_i[i*FIELD_W +: FIELD_W] = field_val(n_sent, i);
        exp_q[i].push_back(field_val(n_sent, i));
      end
      n_sent++;
      holding = 1'b1;
    end
    valid_i = holding;
    ready_i = rdy;
    @(negedge clk);
    #0.5;
    if (valid_i && (&ready_i)) holding = 1'b0;
  endtask

  // Monitor: samples at the falling edge
  always @(negedge clk) begin
    logic [LANES-1:0] exp_v;
    logic [LANES-1:0] hs;
    for (int i = 0; i < LANES; i++) begin
      logic [LANES-1:0] m;
      m = ready_i;
      m[i] = 1'b1;
      exp_v[i] = valid_i & (&m);
    end
    chk(ready_o == (&ready_i), "R1", "ready_o", ready_o, &ready_i);
    chk(valid_o == exp_v, "R2", "valid_o", valid_o, exp_v);
    if (!valid_i) chk(valid_o == '0, "R6", "valid_o idle", valid_o, 0);
    hs = valid_o & ready_i;
    chk(hs == '0 || &hs, "R4", "lane handshakes", hs, 0);
    chk((valid_i & ready_o) == (&hs), "R5", "upstream handshake",
        valid_i & ready_o, &hs);
    if (valid_i) begin
      for (int i = 0; i < LANES; i++)
        chk(data_o[i*FIELD_W +: FIELD_W] == data_i[i*FIELD_W +: FIELD_W],
            "R3", $sformatf("lane %0d field", i),
            data_o[i*FIELD_W +: FIELD_W], data_i[i*FIELD_W +: FIELD_W]);
    end
    if (&hs) n_recv++;
    for (int i = 0; i < LANES; i++) begin
      if (hs[i]) begin
        if (exp_q[i].size() == 0) begin
          chk(1'b0, "R8", $sformatf("lane %0d unexpected item", i),
              data_o[i*FIELD_W +: FIELD_W], 0);
        end else begin
          logic [FIELD_W-1:0] e;
          e = exp_q[i].pop_front();
          chk(data_o[i*FIELD_W +: FIELD_W] == e, "R8",
              $sformatf("lane %0d order", i), data_o[i*FIELD_W +: FIELD_W], e);
        end
      end
    end
  end

  task automatic run_all();
    repeat (3) @(posedge clk);
    #1;
    chk(valid_o == '0, "R6", "reset state valid_o", valid_o, 0);
    rst_n = 1'b1;
    // Directed patterns
    drive_cycle(1'b1, 4'b1111);            // R5: full transfer
    drive_cycle(1'b1, 4'b1110);            // R7: lane 0 stalled
    #0.1;
    chk(valid_o == 4'b0001, "R7", "stalled lane still offered", valid_o, 4'b0001);
    drive_cycle(1'b1, 4'b1010);            // R4: two stalls, nothing moves
    #0.1;
    chk(valid_o == 4'b0000, "R4", "two stalls valid_o", valid_o, 0);
    chk(holding == 1'b1, "R5", "bundle held", holding, 1);
    drive_cycle(1'b1, 4'b0111);            // R7: lane 3 stalled
    #0.1;
    chk(valid_o == 4'b1000, "R7", "lane 3 offered", valid_o, 4'b1000);
    drive_cycle(1'b1, 4'b1111);
    drive_cycle(1'b0, 4'b1111);            // R6: idle upstream
    // Random per-lane stalls
    for (int c = 0; c < RAND_CYC; c++) begin
      logic [LANES-1:0] r;
      for (int i = 0; i < LANES; i++) r[i] = ($urandom_range(0, 9) < 8);
      drive_cycle($urandom_range(0, 3) != 0, r);
    end
    // Drain
    repeat (4) drive_cycle(1'b0, 4'b1111);
    for (int i = 0; i < LANES; i++)
      chk(exp_q[i].size() == 0, "R8", $sformatf("lane %0d leftover", i),
          exp_q[i].size(), 0);
    chk(n_recv == n_sent, "R8", "bundles delivered", n_recv, n_sent);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule